// File: doc/BRIEF.md
# Dual-Bus Message Retry Controller

This block decides what happens after each attempt of a message on a bus controller that owns two redundant buses, named A (`0`) and B (`1`). A message begins with a start pulse that carries the bus the message asked for and the retry strategy. The message engine reports the end of every attempt together with an error flag and a retryable qualifier. The controller answers in the very next cycle with exactly one of three pulses: success, retry on the bus it now drives on `bus_sel_o`, or final failure with the total number of attempts made.

The budget is six retries per message. There are two strategies. In split mode (`alt_mode_i = 0`) the first three retries stay on the requested bus and the last three move to the other bus. In alternate mode (`alt_mode_i = 1`) the first retry goes to the other bus and every later retry toggles the bus again.

The machine has two states. `ST_IDLE` waits for a start, and `ST_WAIT` waits for an attempt to end. The transitions are: start (`ST_IDLE`→`ST_WAIT`), retry (`ST_WAIT`→`ST_WAIT`), success (`ST_WAIT`→`ST_IDLE`), hard failure (`ST_WAIT`→`ST_IDLE`) and exhaustion (`ST_WAIT`→`ST_IDLE`).

Top module: `bus_retry_ctrl`

## Requirements
- R1: After reset `busy_o`, `retry_o`, `ok_o`, `fail_o`, `retry_cnt_o`, `fail_attempts_o` and `bus_sel_o` are all 0.
- R2: A start pulse in `ST_IDLE` sets `busy_o`, drives `bus_sel_o` to `orig_bus_i` and sets `retry_cnt_o` to 0 on the next cycle. The bus and mode are latched at that point. A start pulse during `ST_WAIT` has no effect.
- R3: An attempt end without error (`att_err_i = 0`) gives a one-cycle `ok_o` pulse on the next cycle, with `retry_cnt_o` back at 0 and `busy_o` low.
- R4: An error with `err_retryable_i = 0` gives a one-cycle `fail_o` pulse on the next cycle and no `retry_o`. `fail_attempts_o` is set to the retry count plus 1.
- R5: A retryable error while fewer than 6 retries have been made gives `retry_o` on the next cycle, with no added delay, and increments `retry_cnt_o` by 1.
- R6: In split mode, retries 1 to 3 drive the latched original bus and retries 4 to 6 drive the other bus.
- R7: In alternate mode, odd-numbered retries drive the other bus and even-numbered retries drive the original bus.
- R8: A retryable error after the sixth retry gives `fail_o` with `fail_attempts_o = 7`, no `retry_o`, `retry_cnt_o = 0`, and a return to `ST_IDLE`.
- R9: At most one of `retry_o`, `ok_o` and `fail_o` is high in any cycle, and each is high for one cycle only.
- R10: `att_done_i` while in `ST_IDLE` raises none of `retry_o`, `ok_o` or `fail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | New message begins |
| orig_bus_i | input | 1 | Bus requested by the message (0 = A, 1 = B) |
| alt_mode_i | input | 1 | Strategy: 0 = split, 1 = alternate |
| att_done_i | input | 1 | Attempt finished |
| att_err_i | input | 1 | The attempt failed |
| err_retryable_i | input | 1 | The failure may be retried |
| retry_o | output | 1 | Retry now on `bus_sel_o` |
| ok_o | output | 1 | Message succeeded |
| fail_o | output | 1 | Message failed for good |
| bus_sel_o | output | 1 | Bus for the current attempt |
| retry_cnt_o | output | 3 | Retries made for this message |
| fail_attempts_o | output | 3 | Total attempts made, valid with `fail_o` |
| busy_o | output | 1 | Message in progress |

## Verification
The bench builds the block with its defaults: a six-retry budget and a first leg of three. This keeps every message path short enough to enumerate completely. For both requested buses and both modes, it runs every retry depth from 0 to 6 and ends each one with a success or a hard failure. It also runs the exhaustion path. This covers every retry number's bus choice, the switch after the first leg, and the final seventh attempt.

// File: rtl/retry_pkg.sv
package retry_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rc_state_e;
endpackage

// File: rtl/retry_bus_pick.sv
module retry_bus_pick #(
    parameter int CNT_W     = 3,
    parameter int FIRST_LEG = 3
) (
    input  logic             orig_bus,
    input  logic             alt_mode,
    input  logic [CNT_W-1:0] retry_num,
    output logic             bus
);
    localparam logic [CNT_W-1:0] LEG = CNT_W'(FIRST_LEG);

    always_comb begin
        if (alt_mode) begin
            bus = retry_num[0] ? ~orig_bus : orig_bus;
        end else begin
            bus = (retry_num > LEG) ? ~orig_bus : orig_bus;
        end
    end
endmodule

// File: rtl/retry_counter.sv
module retry_counter #(
    parameter int CNT_W = 3,
    parameter int LIMIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

    assign at_limit = (count == LIM);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (count == $past(count) + CNT_W'(1)));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIM);
endmodule

// File: rtl/bus_retry_ctrl.sv
module bus_retry_ctrl
    import retry_pkg::*;
#(
    parameter int RETRY_MAX = 6,
    parameter int FIRST_LEG = 3,
    localparam int CNT_W    = $clog2(RETRY_MAX + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             orig_bus_i,
    input  logic             alt_mode_i,
    input  logic             att_done_i,
    input  logic             att_err_i,
    input  logic             err_retryable_i,
    output logic             retry_o,
    output logic             ok_o,
    output logic             fail_o,
    output logic             bus_sel_o,
    output logic [CNT_W-1:0] retry_cnt_o,
    output logic [CNT_W-1:0] fail_attempts_o,
    output logic             busy_o
);
    rc_state_e state_q, state_d;
    logic orig_q, mode_q;
    logic take_start, ev_ok, ev_hard, ev_retry, ev_exhaust, finish;
    logic at_limit, next_bus;
    logic [CNT_W-1:0] cnt_next;

    // Event decode
    assign take_start = (state_q == ST_IDLE) && start_i;
    assign ev_ok      = (state_q == ST_WAIT) && att_done_i && !att_err_i;
    assign ev_hard    = (state_q == ST_WAIT) && att_done_i && att_err_i && !err_retryable_i;
    assign ev_retry   = (state_q == ST_WAIT) && att_done_i && att_err_i && err_retryable_i && !at_limit;
    assign ev_exhaust = (state_q == ST_WAIT) && att_done_i && att_err_i && err_retryable_i && at_limit;
    assign finish     = ev_ok || ev_hard || ev_exhaust;
    assign cnt_next   = retry_cnt_o + CNT_W'(1);

    retry_counter #(.CNT_W(CNT_W), .LIMIT(RETRY_MAX)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (take_start || finish),
        .inc      (ev_retry),
        .count    (retry_cnt_o),
        .at_limit (at_limit)
    );

    retry_bus_pick #(.CNT_W(CNT_W), .FIRST_LEG(FIRST_LEG)) u_pick (
        .orig_bus  (orig_q),
        .alt_mode  (mode_q),
        .retry_num (cnt_next),
        .bus       (next_bus)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take_start) state_d = ST_WAIT;
            ST_WAIT: if (finish)     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_o         <= 1'b0;
            ok_o            <= 1'b0;
            fail_o          <= 1'b0;
            bus_sel_o       <= 1'b0;
            orig_q          <= 1'b0;
            mode_q          <= 1'b0;
            fail_attempts_o <= '0;
        end else begin
            retry_o <= ev_retry;
            ok_o    <= ev_ok;
            fail_o  <= ev_hard || ev_exhaust;
            if (take_start) begin
                bus_sel_o <= orig_bus_i;
                orig_q    <= orig_bus_i;
                mode_q    <= alt_mode_i;
            end
            if (ev_retry) bus_sel_o <= next_bus;
            if (ev_hard || ev_exhaust) fail_attempts_o <= cnt_next;
        end
    end

    assign busy_o = (state_q == ST_WAIT);

    // R9
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retry_o, ok_o, fail_o}));

    // R3
    ok_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && att_done_i && !att_err_i) |=> (ok_o && !busy_o && retry_cnt_o == '0));

    // R4
    hard_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && att_done_i && att_err_i && !err_retryable_i) |=> (fail_o && !retry_o));

    // R7
    alt_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_o && mode_q && retry_cnt_o[0]) |-> (bus_sel_o != orig_q));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o) |=> !(retry_o || ok_o || fail_o));
endmodule

// File: tb/bus_retry_ctrl_test.sv
module bus_retry_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, orig_bus_i = 0, alt_mode_i = 0;
    logic att_done_i = 0, att_err_i = 0, err_retryable_i = 0;
    logic retry_o, ok_o, fail_o, bus_sel_o, busy_o;
    logic [2:0] retry_cnt_o, fail_attempts_o;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_retry_ctrl uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_msg(input logic ob, input logic md);
        @(negedge clk);
        start_i = 1; orig_bus_i = ob; alt_mode_i = md;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic attempt(input logic err, input logic rtr);
        @(negedge clk);
        att_done_i = 1; att_err_i = err; err_retryable_i = rtr;
        @(negedge clk);
        att_done_i = 0; att_err_i = 0; err_retryable_i = 0;
    endtask

    function automatic logic exp_bus(input logic ob, input logic md, input int k);
        if (md) return (k % 2 == 1) ? ~ob : ob;
        return (k > 3) ? ~ob : ob;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", busy_o, 0);
        chk("R1 pulses", {retry_o, ok_o, fail_o}, 0);
        chk("R1 cnt", retry_cnt_o, 0);
        chk("R1 bus", bus_sel_o, 0);
        chk("R1 attempts", fail_attempts_o, 0);
        rst_n = 1;

        attempt(1, 1);
        chk("R10 idle done", {retry_o, ok_o, fail_o}, 0);

        for (int ob = 0; ob < 2; ob++) begin
            for (int md = 0; md < 2; md++) begin
                for (int nret = 0; nret <= 7; nret++) begin
                    for (int oc = 0; oc < 2; oc++) begin
                        if (nret == 7 && oc == 1) continue;
                        start_msg(ob[0], md[0]);
                        chk("R2 busy", busy_o, 1);
                        chk("R2 bus", bus_sel_o, ob);
                        chk("R2 cnt", retry_cnt_o, 0);
                        // start while busy with flipped bus: ignored
                        start_msg(~ob[0], ~md[0]);
                        chk("R2 ignored", bus_sel_o, ob);
                        for (int k = 1; k <= ((nret == 7) ? 6 : nret); k++) begin
                            attempt(1, 1);
                            chk("R5 retry", retry_o, 1);
                            chk("R9 single", ok_o | fail_o, 0);
                            chk("R5 cnt", retry_cnt_o, k);
                            chk(md ? "R7 bus" : "R6 bus", bus_sel_o, exp_bus(ob[0], md[0], k));
                            @(negedge clk);
                            chk("R9 one cycle", retry_o, 0);
                        end
                        if (nret == 7) begin
                            attempt(1, 1);
                            chk("R8 fail", fail_o, 1);
                            chk("R8 no retry", retry_o, 0);
                            chk("R8 attempts", fail_attempts_o, 7);
                            chk("R8 cnt", retry_cnt_o, 0);
                            chk("R8 idle", busy_o, 0);
                        end else if (oc == 0) begin
                            attempt(0, 0);
                            chk("R3 ok", ok_o, 1);
                            chk("R3 cnt", retry_cnt_o, 0);
                            chk("R3 idle", busy_o, 0);
                            chk("R9 single", retry_o | fail_o, 0);
                        end else begin
                            attempt(1, 0);
                            chk("R4 fail", fail_o, 1);
                            chk("R4 no retry", retry_o, 0);
                            chk("R4 attempts", fail_attempts_o, nret + 1);
                        end
                        @(negedge clk);
                        chk("R9 one cycle", {retry_o, ok_o, fail_o}, 0);
                    end
                end
            end
        end
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule